// File: doc/BRIEF.md
# Precision Time Clock with Rate Trim and Step Offset

This block keeps a running time of day made of a 32-bit seconds count, a nanoseconds count that wraps at one billion, and a 32-bit binary fraction of a nanosecond. A timing reference strobe `tick_i` marks each 40 ns period of the reference. While counting is enabled, every strobe adds 40 ns. When rate trim is on, a signed correction, kept as a magnitude plus a direction bit, is also added on every strobe. The full running time leaves the block on dedicated outputs so that compare and capture logic elsewhere can use it.

Software drives the block through a simple register port with write and read strobes. A control register holds the enables and the step direction, and it carries three command bits that clear themselves: take a snapshot, load a time, and apply a step. The snapshot copies the running seconds and nanoseconds into shadow registers. In the same cycle it also copies a sub-phase, which counts 8 ns system clock periods since the last reference strobe. Software adds sub-phase × 8 to the shadow nanoseconds to get a finer reading. The load and step commands take their operands from the same shadow seconds and nanoseconds registers.

Register map (word addresses): 0 control, 1 shadow seconds, 2 shadow nanoseconds, 3 sub-phase (read-only), 4 rate. Control register bits:

| Bit | Function |
|-----|----------|
| 0 | count enable |
| 1 | rate-trim enable |
| 2 | step direction, 1 = add |
| 3 | snapshot command |
| 4 | load command |
| 5 | step command |

Rate register fields: bits [29:0] hold the magnitude in units of 2^-32 ns per strobe; bit 31 is the direction, where 1 speeds the clock up.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset the time outputs are zero, and every register at addresses 0 to 4 reads back zero.
- R2: A strobe on `tick_i` changes the time only while control bit 0 is 1; with bit 0 clear, strobes leave seconds, nanoseconds and fraction unchanged.
- R3: Each counted strobe without rate trim adds exactly 40 ns. When the nanoseconds reach 1,000,000,000 they wrap by that amount and the seconds go up by one. The update is visible on the outputs after the clock edge that samples the strobe.
- R4: While control bit 1 is set, each counted strobe adds 40 ns plus the rate magnitude (rate bits [29:0], units of 2^-32 ns) if rate bit 31 is 1, or minus the magnitude if rate bit 31 is 0. Carries and borrows pass through the 32-bit fraction on `time_frac_o`.
- R5: With control bit 1 clear, a counted strobe adds exactly 40 ns and leaves the fraction unchanged.
- R6: The snapshot command (control bit 3) copies seconds and nanoseconds into the shadow registers at the edge after the write edge. At that edge the sub-phase (address 3, bits [7:0]) takes the number of clock edges since the last strobe edge, counting the strobe edge as 1 and saturating at 255.
- R7: The load command (control bit 4) sets the running seconds and nanoseconds to the shadow values and the fraction to zero, at the edge after the write edge.
- R8: The step command (control bit 5) adds the shadow seconds and nanoseconds to the running time when control bit 2 is 1, and subtracts them when it is 0. A nanoseconds overflow carries into seconds and an underflow borrows from seconds. It takes effect at the edge after the write edge.
- R9: Command bits 3 to 5 read back as zero after their action, while bits 0 to 2 keep the written values.
- R10: When load and step are requested together, load wins and the step is discarded.
- R11: Writes to address 3 are ignored; the sub-phase changes only by snapshot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timing reference strobe, one per 40 ns period |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe; data appears on the next cycle |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| time_sec_o | output | 32 | Running seconds |
| time_ns_o | output | 30 | Running nanoseconds, 0 to 999,999,999 |
| time_frac_o | output | 32 | Running fraction of a nanosecond |

## Verification
The running time is on the ports every cycle, so a wrong increment, a wrong carry or a wrong rate accumulation shows on the outputs at the first strobe after the fault, and the bench compares the outputs against an arithmetic model after every burst. A wrong snapshot or sub-phase only shows once software reads the shadow registers, so the bench reads them back right after each snapshot, across a sweep of delays after a strobe. Step and load faults show in the edge after the command, for both directions and for both the carry and the borrow case.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;
  localparam int unsigned SEC_W       = 32;
  localparam int unsigned NS_W        = 30;
  localparam int unsigned FRAC_W      = 32;
  localparam int unsigned RATE_W      = 30;
  localparam int unsigned PHASE_W     = 8;
  localparam int unsigned ADDR_W      = 3;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned NOM_INC_NS  = 40;
  localparam int unsigned NS_PER_SEC  = 1_000_000_000;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_SEC   = 3'd1;
  localparam logic [ADDR_W-1:0] A_NS    = 3'd2;
  localparam logic [ADDR_W-1:0] A_PHASE = 3'd3;
  localparam logic [ADDR_W-1:0] A_RATE  = 3'd4;

  localparam int unsigned CB_CNT_EN = 0;
  localparam int unsigned CB_ADJ_EN = 1;
  localparam int unsigned CB_DIR    = 2;
  localparam int unsigned CB_SNAP   = 3;
  localparam int unsigned CB_LOAD   = 4;
  localparam int unsigned CB_STEP   = 5;
  localparam int unsigned RB_UP     = 31;

  typedef struct packed {
    logic snap;
    logic load;
    logic step;
  } cmd_t;
endpackage

// File: rtl/ptp_tc_regs.sv
module ptp_tc_regs
  import ptp_tc_pkg::*;
#(
  parameter int unsigned SW = SEC_W,
  parameter int unsigned NW = NS_W,
  parameter int unsigned RW = RATE_W,
  parameter int unsigned PW = PHASE_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [SW-1:0] run_sec_i,
  input  logic [NW-1:0] run_ns_i,
  input  logic [PW-1:0] run_phase_i,
  output logic          cnt_en_o,
  output logic          adj_en_o,
  output logic          dir_o,
  output cmd_t          cmd_o,
  output logic [SW-1:0] sh_sec_o,
  output logic [NW-1:0] sh_ns_o,
  output logic [RW-1:0] rate_mag_o,
  output logic          rate_up_o
);
  logic          cnt_en_q, adj_en_q, dir_q, rate_up_q;
  cmd_t          cmd_q;
  logic [SW-1:0] sh_sec_q;
  logic [NW-1:0] sh_ns_q;
  logic [PW-1:0] sh_ph_q;
  logic [RW-1:0] mag_q;
  logic [DW-1:0] rdata_q, rd_mux;
  logic          wr_ctrl;

  assign wr_ctrl = wr_i && (addr_i == A_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_en_q <= 1'b0;
      adj_en_q <= 1'b0;
      dir_q    <= 1'b0;
      cmd_q    <= '0;
    end else begin
      cmd_q <= '0;
      if (wr_ctrl) begin
        cnt_en_q   <= wdata_i[CB_CNT_EN];
        adj_en_q   <= wdata_i[CB_ADJ_EN];
        dir_q      <= wdata_i[CB_DIR];
        cmd_q.snap <= wdata_i[CB_SNAP];
        cmd_q.load <= wdata_i[CB_LOAD];
        cmd_q.step <= wdata_i[CB_STEP];
      end
    end
  end

  // snapshot wins over a software write in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_sec_q <= '0;
      sh_ns_q  <= '0;
      sh_ph_q  <= '0;
    end else if (cmd_q.snap) begin
      sh_sec_q <= run_sec_i;
      sh_ns_q  <= run_ns_i;
      sh_ph_q  <= run_phase_i;
    end else if (wr_i) begin
      if (addr_i == A_SEC) sh_sec_q <= wdata_i[SW-1:0];
      if (addr_i == A_NS)  sh_ns_q  <= wdata_i[NW-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mag_q     <= '0;
      rate_up_q <= 1'b0;
    end else if (wr_i && addr_i == A_RATE) begin
      mag_q     <= wdata_i[RW-1:0];
      rate_up_q <= wdata_i[RB_UP];
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (addr_i)
      A_CTRL: begin
        rd_mux[CB_CNT_EN] = cnt_en_q;
        rd_mux[CB_ADJ_EN] = adj_en_q;
        rd_mux[CB_DIR]    = dir_q;
        rd_mux[CB_SNAP]   = cmd_q.snap;
        rd_mux[CB_LOAD]   = cmd_q.load;
        rd_mux[CB_STEP]   = cmd_q.step;
      end
      A_SEC:   rd_mux = DW'(sh_sec_q);
      A_NS:    rd_mux = DW'(sh_ns_q);
      A_PHASE: rd_mux = DW'(sh_ph_q);
      A_RATE: begin
        rd_mux[RW-1:0] = mag_q;
        rd_mux[RB_UP]  = rate_up_q;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o    = rdata_q;
  assign cnt_en_o   = cnt_en_q;
  assign adj_en_o   = adj_en_q;
  assign dir_o      = dir_q;
  assign cmd_o      = cmd_q;
  assign sh_sec_o   = sh_sec_q;
  assign sh_ns_o    = sh_ns_q;
  assign rate_mag_o = mag_q;
  assign rate_up_o  = rate_up_q;

  AST_CMD_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q != '0 && !wr_ctrl) |=> (cmd_q == '0)); // R9
  AST_PHASE_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_q.snap) |=> $stable(sh_ph_q)); // R11
endmodule

// File: rtl/ptp_tc_rate.sv
module ptp_tc_rate
  import ptp_tc_pkg::*;
#(
  parameter int unsigned FW  = FRAC_W,
  parameter int unsigned RW  = RATE_W,
  parameter int unsigned NOM = NOM_INC_NS,
  localparam int unsigned IW = $clog2(NOM + 2)
) (
  input  logic [FW-1:0] frac_i,
  input  logic          adj_en_i,
  input  logic [RW-1:0] mag_i,
  input  logic          up_i,
  output logic [FW-1:0] frac_next_o,
  output logic [IW-1:0] ns_inc_o
);
  logic [FW:0] mag_ext, acc;

  assign mag_ext = (FW+1)'(mag_i);

  // sign-magnitude trim: carry adds 1 ns, borrow removes 1 ns
  always_comb begin
    if (!adj_en_i) begin
      acc      = {1'b0, frac_i};
      ns_inc_o = IW'(NOM);
    end else if (up_i) begin
      acc      = {1'b0, frac_i} + mag_ext;
      ns_inc_o = IW'(NOM) + IW'(acc[FW]);
    end else begin
      acc      = {1'b0, frac_i} - mag_ext;
      ns_inc_o = IW'(NOM) - IW'(acc[FW]);
    end
  end

  assign frac_next_o = acc[FW-1:0];
endmodule

// File: rtl/ptp_tc_counter.sv
module ptp_tc_counter
  import ptp_tc_pkg::*;
#(
  parameter int unsigned SW   = SEC_W,
  parameter int unsigned NW   = NS_W,
  parameter int unsigned FW   = FRAC_W,
  parameter int unsigned PW   = PHASE_W,
  parameter int unsigned NOM  = NOM_INC_NS,
  parameter int unsigned WRAP = NS_PER_SEC,
  localparam int unsigned IW  = $clog2(NOM + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          cnt_en_i,
  input  logic          load_i,
  input  logic          step_i,
  input  logic          dir_i,
  input  logic [SW-1:0] sh_sec_i,
  input  logic [NW-1:0] sh_ns_i,
  input  logic [IW-1:0] ns_inc_i,
  input  logic [FW-1:0] frac_next_i,
  output logic [SW-1:0] sec_o,
  output logic [NW-1:0] ns_o,
  output logic [FW-1:0] frac_o,
  output logic [PW-1:0] phase_o
);
  localparam logic [NW:0]   WRAP_V = (NW+1)'(WRAP);
  localparam logic [PW-1:0] PH_MAX = '1;

  logic [SW-1:0] sec_q;
  logic [NW-1:0] ns_q;
  logic [FW-1:0] frac_q;
  logic [PW-1:0] ph_q;

  logic [NW:0]   tick_sum, fwd_sum, bwd_diff, ns_tick, ns_step;
  logic          tick_wrap, fwd_wrap, bwd_borrow;
  logic [SW-1:0] sec_tick, sec_step;

  always_comb begin
    tick_sum   = {1'b0, ns_q} + (NW+1)'(ns_inc_i);
    tick_wrap  = tick_sum >= WRAP_V;
    ns_tick    = tick_wrap ? tick_sum - WRAP_V : tick_sum;
    sec_tick   = sec_q + SW'(tick_wrap);

    fwd_sum    = {1'b0, ns_q} + {1'b0, sh_ns_i};
    fwd_wrap   = fwd_sum >= WRAP_V;
    bwd_borrow = ns_q < sh_ns_i;
    bwd_diff   = {1'b0, ns_q} - {1'b0, sh_ns_i};
    if (dir_i) begin
      ns_step  = fwd_wrap ? fwd_sum - WRAP_V : fwd_sum;
      sec_step = sec_q + sh_sec_i + SW'(fwd_wrap);
    end else begin
      ns_step  = bwd_borrow ? bwd_diff + WRAP_V : bwd_diff;
      sec_step = sec_q - sh_sec_i - SW'(bwd_borrow);
    end
  end

  // load > step > counted tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q  <= '0;
      ns_q   <= '0;
      frac_q <= '0;
    end else if (load_i) begin
      sec_q  <= sh_sec_i;
      ns_q   <= sh_ns_i;
      frac_q <= '0;
    end else if (step_i) begin
      sec_q  <= sec_step;
      ns_q   <= ns_step[NW-1:0];
    end else if (tick_i && cnt_en_i) begin
      sec_q  <= sec_tick;
      ns_q   <= ns_tick[NW-1:0];
      frac_q <= frac_next_i;
    end
  end

  // edges since last strobe edge, strobe edge counts as 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             ph_q <= '0;
    else if (tick_i)         ph_q <= PW'(1);
    else if (ph_q != PH_MAX) ph_q <= ph_q + PW'(1);
  end

  assign sec_o   = sec_q;
  assign ns_o    = ns_q;
  assign frac_o  = frac_q;
  assign phase_o = ph_q;

  AST_NS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, ns_q} < WRAP_V)); // R3
  AST_HOLD_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_en_i && !load_i && !step_i) |=> ($stable(sec_q) && $stable(ns_q) && $stable(frac_q))); // R2
  AST_TICK_STEP_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_en_i && !load_i && !step_i) |=>
      (((ns_q >= $past(ns_q)) ? ({1'b0, ns_q} - {1'b0, $past(ns_q)})
                              : ({1'b0, ns_q} + WRAP_V - {1'b0, $past(ns_q)})) >= (NW+1)'(NOM - 1)) &&
      (((ns_q >= $past(ns_q)) ? ({1'b0, ns_q} - {1'b0, $past(ns_q)})
                              : ({1'b0, ns_q} + WRAP_V - {1'b0, $past(ns_q)})) <= (NW+1)'(NOM + 1))); // R4
  AST_LOAD_FRAC_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (frac_q == '0 && ns_q == $past(sh_ns_i))); // R7
  AST_LOAD_PRIORITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && step_i) |=> (sec_q == $past(sh_sec_i))); // R10
  AST_STEP_FWD_SEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && dir_i) |=>
      (sec_q == $past(sec_q) + $past(sh_sec_i) || sec_q == $past(sec_q) + $past(sh_sec_i) + SW'(1))); // R8
endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
  import ptp_tc_pkg::*;
#(
  parameter int unsigned SW = SEC_W,
  parameter int unsigned NW = NS_W,
  parameter int unsigned FW = FRAC_W,
  parameter int unsigned RW = RATE_W,
  parameter int unsigned PW = PHASE_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [SW-1:0] time_sec_o,
  output logic [NW-1:0] time_ns_o,
  output logic [FW-1:0] time_frac_o
);
  localparam int unsigned IW = $clog2(NOM_INC_NS + 2);

  logic          cnt_en, adj_en, dir, rate_up;
  cmd_t          cmd;
  logic [SW-1:0] sh_sec, sec;
  logic [NW-1:0] sh_ns, ns;
  logic [FW-1:0] frac, frac_next;
  logic [RW-1:0] rate_mag;
  logic [PW-1:0] phase;
  logic [IW-1:0] ns_inc;

  ptp_tc_regs #(.SW(SW), .NW(NW), .RW(RW), .PW(PW), .AW(AW), .DW(DW)) u_regs (
    .clk_i, .rst_ni, .wr_i, .rd_i, .addr_i, .wdata_i, .rdata_o,
    .run_sec_i(sec), .run_ns_i(ns), .run_phase_i(phase),
    .cnt_en_o(cnt_en), .adj_en_o(adj_en), .dir_o(dir), .cmd_o(cmd),
    .sh_sec_o(sh_sec), .sh_ns_o(sh_ns), .rate_mag_o(rate_mag), .rate_up_o(rate_up)
  );

  ptp_tc_rate #(.FW(FW), .RW(RW), .NOM(NOM_INC_NS)) u_rate (
    .frac_i(frac), .adj_en_i(adj_en), .mag_i(rate_mag), .up_i(rate_up),
    .frac_next_o(frac_next), .ns_inc_o(ns_inc)
  );

  ptp_tc_counter #(.SW(SW), .NW(NW), .FW(FW), .PW(PW), .NOM(NOM_INC_NS), .WRAP(NS_PER_SEC)) u_cnt (
    .clk_i, .rst_ni, .tick_i, .cnt_en_i(cnt_en), .load_i(cmd.load), .step_i(cmd.step),
    .dir_i(dir), .sh_sec_i(sh_sec), .sh_ns_i(sh_ns), .ns_inc_i(ns_inc),
    .frac_next_i(frac_next), .sec_o(sec), .ns_o(ns), .frac_o(frac), .phase_o(phase)
  );

  assign time_sec_o  = sec;
  assign time_ns_o   = ns;
  assign time_frac_o = frac;
endmodule

// File: tb/tb_ptp_time_counter.sv
module tb_ptp_time_counter;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [31:0] time_sec_o;
  logic [29:0] time_ns_o;
  logic [31:0] time_frac_o;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model of the time
  longint m_sec, m_ns, m_frac, m_mag;
  bit     m_adj, m_up;
  localparam longint BIL = 1_000_000_000;
  localparam longint F1  = 64'h1_0000_0000;
  localparam logic [31:0] EN = 32'h1, ADJ = 32'h2, DIR = 32'h4,
                          SNAP = 32'h8, LOAD = 32'h10, STEP = 32'h20;

  ptp_time_counter dut (
    .clk_i(clk), .rst_ni, .tick_i, .wr_i, .rd_i, .addr_i, .wdata_i,
    .rdata_o, .time_sec_o, .time_ns_o, .time_frac_o
  );

  always #4 clk = ~clk;

  task automatic chk(string req, string what, longint got, longint exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %0d exp %0d", req, what, got, exp);
    end
  endtask

  task automatic chk_time(string req);
    chk(req, "sec", longint'(time_sec_o), m_sec);
    chk(req, "ns", longint'(time_ns_o), m_ns);
    chk(req, "frac", longint'(time_frac_o), m_frac);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk); wr_i = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output longint d);
    @(negedge clk); rd_i = 1'b1; addr_i = a;
    @(negedge clk); rd_i = 1'b0; d = longint'(rdata_o);
  endtask

  // issue a command write, then let the action edge pass
  task automatic cmd(logic [31:0] d);
    wr(3'd0, d);
    @(negedge clk);
  endtask

  task automatic model_tick(bit en);
    longint inc;
    if (!en) return;
    inc = 40;
    if (m_adj) begin
      m_frac = m_up ? m_frac + m_mag : m_frac - m_mag;
      if (m_frac >= F1) begin m_frac -= F1; inc++; end
      if (m_frac < 0)   begin m_frac += F1; inc--; end
    end
    m_ns += inc;
    if (m_ns >= BIL) begin m_ns -= BIL; m_sec++; end
  endtask

  task automatic ticks(int n, bit en);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
      model_tick(en);
    end
  endtask

  task automatic load(longint s, longint n, logic [31:0] ctl);
    wr(3'd1, s[31:0]); wr(3'd2, n[31:0]);
    cmd(ctl | LOAD);
    m_sec = s; m_ns = n; m_frac = 0;
  endtask

  task automatic step(longint s, longint n, bit add);
    longint tot;
    wr(3'd1, s[31:0]); wr(3'd2, n[31:0]);
    cmd(STEP | (add ? DIR : 32'h0));
    tot = m_sec * BIL + m_ns;
    tot = add ? tot + (s * BIL + n) : tot - (s * BIL + n);
    m_sec = tot / BIL; m_ns = tot % BIL;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    longint d;
    longint mags[3] = '{64'h2000_0000, 64'h3FFF_FFFF, 64'd12345};
    m_sec = 0; m_ns = 0; m_frac = 0; m_mag = 0; m_adj = 0; m_up = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    chk_time("R1");
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      chk("R1", "reg", d, 0);
    end

    // R2 strobes ignored while disabled
    ticks(10, 0);
    chk_time("R2");

    // R7 load, counting still off
    load(5, BIL - 80, 32'h0);
    chk_time("R7");

    // R3 sweep across the seconds wrap
    for (int j = 0; j < 8; j++) begin
      load(longint'(j), BIL - 100 + 4 * j, EN);
      ticks(4, 1);
      chk_time("R3");
    end

    // R4 rate trim both directions, several magnitudes
    for (int up = 0; up < 2; up++) begin
      for (int k = 0; k < 3; k++) begin
        m_mag = mags[k]; m_up = (up == 1); m_adj = 1;
        wr(3'd4, {m_up, 1'b0, mags[k][29:0]});
        load(100, 0, EN | ADJ);
        ticks(20, 1);
        chk_time("R4");
      end
    end

    // R5 trim off: plain 40 ns, fraction held
    cmd(EN);
    m_adj = 0;
    ticks(5, 1);
    chk_time("R5");

    // R7 load clears a nonzero fraction
    m_adj = 1;
    cmd(EN | ADJ);
    ticks(3, 1);
    load(9, 1234, EN);
    m_adj = 0;
    chk_time("R7");

    // R6 snapshot sub-phase sweep
    for (int a = 0; a < 6; a++) begin
      load(7, 500, EN);
      ticks(1, 1);
      repeat (a) @(negedge clk);
      cmd(EN | SNAP);
      rd(3'd1, d); chk("R6", "shadow sec", d, m_sec);
      rd(3'd2, d); chk("R6", "shadow ns", d, m_ns);
      rd(3'd3, d); chk("R6", "phase", d, longint'(a + 3));
    end

    // R11 phase register ignores writes
    wr(3'd3, 32'hFF);
    rd(3'd3, d); chk("R11", "phase after write", d, 8);

    // R8 step: carry, borrow, both directions
    load(10, BIL - 50, 32'h0);
    step(3, 100, 1);   chk_time("R8");
    step(3, 100, 0);   chk_time("R8");
    load(10, 50, 32'h0);
    step(3, 100, 0);   chk_time("R8");
    step(0, 999_999_999, 1); chk_time("R8");

    // R9 command bits self-clear, enables retained
    cmd(EN | ADJ | DIR | SNAP);
    rd(3'd0, d); chk("R9", "ctrl", d, 7);

    // R10 load beats step
    wr(3'd1, 20); wr(3'd2, 300);
    cmd(LOAD | STEP | DIR);
    m_sec = 20; m_ns = 300; m_frac = 0;
    chk_time("R10");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule